// File: doc/BRIEF.md
# Energy-Aware Reconfiguration Manager

This block chooses which of two task implementations a reconfigurable coprocessor should hold. Each time the host finishes a task it sends a checkpoint event naming the task that ran. The manager keeps these identities in a sliding history of recent executions. The task that makes up the majority of that history is the preferred task.

A stream of digital power readings from the energy harvester is compared with a reconfiguration power threshold. A swap is requested only when three things hold: the history is full, the preferred task differs from the loaded one, and a reading above the threshold arrives. Swaps therefore run on surplus harvested energy rather than on stored charge. The burst length is never needed.

The request is a single interrupt line that stays high until the host acknowledges it. A task-select output names the task to load. The host later reports completion, and the manager then updates a status output that the host reads to learn which task is resident. Both input streams use valid/ready. Their ready outputs are tied high, so the manager never applies back-pressure, and a beat transfers on every clock edge where valid is high.

Top module: `rcfg_mgr`

## Requirements
- R1: After reset, `irq` is 0, `req_task` is 0, and `status_task` equals the parameter `INIT_TASK` (default 0).
- R2: A checkpoint beat with `ckpt_code` 1 records task 0, and `ckpt_code` 2 records task 1. Codes 0 and 3 are dropped and leave the history untouched.
- R3: The preferred task is whichever task holds more than half of the most recent `WIN` recorded checkpoints (default 15, odd). Older entries leave the window as new ones arrive.
- R4: No request is raised until `WIN` checkpoints have been recorded since reset. A checkpoint recorded at the same edge as a power sample does not count for that sample.
- R5: A request needs a power beat with `pwr_sample` strictly greater than `reconf_thresh`. A sample equal to the threshold does not trigger one.
- R6: No request is raised while the preferred task equals `status_task`.
- R7: Once raised, `irq` stays high and `req_task` stays stable until `irq_ack` or `reconf_done` is seen.
- R8: From a request until `reconf_done`, no further request is raised, including after `irq_ack`.
- R9: `reconf_done` during an outstanding request copies `req_task` into `status_task` one cycle later and clears `irq`. At other times, `reconf_done` is ignored.
- R10: `ckpt_ready` and `pwr_ready` are always 1. Power samples with `pwr_valid` low have no effect.
- R11: `irq` rises on the clock edge that accepts the triggering power beat, and `req_task` holds the preferred task at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ckpt_valid | input | 1 | Checkpoint beat valid |
| ckpt_ready | output | 1 | Checkpoint ready, always 1 |
| ckpt_code | input | 2 | Event code: 1 = task 0, 2 = task 1, others dropped |
| pwr_valid | input | 1 | Power sample valid |
| pwr_ready | output | 1 | Power ready, always 1 |
| pwr_sample | input | PW | Measured harvested power |
| reconf_thresh | input | PW | Reconfiguration power threshold |
| irq | output | 1 | Reconfiguration request to host |
| irq_ack | input | 1 | Host acknowledge of `irq` |
| req_task | output | 1 | Task to be loaded |
| reconf_done | input | 1 | Host reports the load finished |
| status_task | output | 1 | Task currently resident |

## Verification
A wrong ones count or fill count in the history shows up at the ports as a request that comes too early or names the wrong task. It also shows up as a missing request on the first burst after the window tips. The directed tests build windows one entry away from a tie so that any such error becomes visible within one power beat. A busy flag stuck high or low shows as a missing request, or as an extra `irq` rise after acknowledge. The window that exposes this lies between `irq_ack` and `reconf_done`.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  typedef logic task_id_t;

  localparam logic [1:0] CODE_TASK0 = 2'd1;
  localparam logic [1:0] CODE_TASK1 = 2'd2;

  function automatic logic code_is_task(input logic [1:0] code);
    return (code == CODE_TASK0) || (code == CODE_TASK1);
  endfunction

  function automatic task_id_t code_to_task(input logic [1:0] code);
    return task_id_t'(code == CODE_TASK1);
  endfunction
endpackage

// File: rtl/rcfg_window.sv
module rcfg_window #(
  parameter int WIN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic bit_in,
  output logic full,
  output logic majority
);
  localparam int CW = $clog2(WIN + 1);

  logic [WIN-1:0] hist_q;
  logic [CW-1:0]  ones_q;
  logic [CW-1:0]  fill_q;
  logic           full_q;
  logic [CW-1:0]  add_v;
  logic [CW-1:0]  sub_v;

  assign full_q = (fill_q == CW'(WIN));
  assign add_v  = CW'(bit_in);
  assign sub_v  = full_q ? CW'(hist_q[WIN-1]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      ones_q <= '0;
      fill_q <= '0;
    end else if (push) begin
      hist_q <= {hist_q[WIN-2:0], bit_in};
      ones_q <= ones_q + add_v - sub_v;
      if (!full_q) fill_q <= fill_q + 1'b1;
    end
  end

  assign full     = full_q;
  assign majority = ((32'(ones_q) * 2) > WIN);
endmodule

// File: rtl/rcfg_burst_cmp.sv
module rcfg_burst_cmp #(
  parameter int PW = 12
) (
  input  logic          valid,
  input  logic [PW-1:0] sample,
  input  logic [PW-1:0] thresh,
  output logic          surplus
);
  assign surplus = valid && (sample > thresh);
endmodule

// File: rtl/rcfg_req_ctrl.sv
module rcfg_req_ctrl
  import rcfg_pkg::*;
#(
  parameter bit INIT_TASK = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     win_full,
  input  task_id_t pref,
  input  logic     surplus,
  input  logic     ack,
  input  logic     done,
  output logic     irq,
  output task_id_t req,
  output task_id_t loaded
);
  logic     irq_q, busy_q;
  task_id_t req_q, loaded_q;
  logic     launch;

  assign launch = win_full && surplus && !busy_q && (pref != loaded_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      busy_q   <= 1'b0;
      req_q    <= task_id_t'(0);
      loaded_q <= task_id_t'(INIT_TASK);
    end else if (launch) begin
      irq_q  <= 1'b1;
      busy_q <= 1'b1;
      req_q  <= pref;
    end else if (busy_q && done) begin
      irq_q    <= 1'b0;
      busy_q   <= 1'b0;
      loaded_q <= req_q;
    end else if (ack) begin
      irq_q <= 1'b0;
    end
  end

  assign irq    = irq_q;
  assign req    = req_q;
  assign loaded = loaded_q;
endmodule

// File: rtl/rcfg_mgr.sv
module rcfg_mgr
  import rcfg_pkg::*;
#(
  parameter int WIN       = 15,
  parameter int PW        = 12,
  parameter bit INIT_TASK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ckpt_valid,
  output logic          ckpt_ready,
  input  logic [1:0]    ckpt_code,
  input  logic          pwr_valid,
  output logic          pwr_ready,
  input  logic [PW-1:0] pwr_sample,
  input  logic [PW-1:0] reconf_thresh,
  output logic          irq,
  input  logic          irq_ack,
  output logic          req_task,
  input  logic          reconf_done,
  output logic          status_task
);
  logic win_push, win_full, win_major, surplus;

  assign ckpt_ready = 1'b1;
  assign pwr_ready  = 1'b1;
  assign win_push   = ckpt_valid && code_is_task(ckpt_code);

  rcfg_window #(.WIN(WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .push(win_push),
    .bit_in(code_to_task(ckpt_code)), .full(win_full), .majority(win_major)
  );

  rcfg_burst_cmp #(.PW(PW)) u_cmp (
    .valid(pwr_valid), .sample(pwr_sample), .thresh(reconf_thresh),
    .surplus(surplus)
  );

  rcfg_req_ctrl #(.INIT_TASK(INIT_TASK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .win_full(win_full), .pref(win_major),
    .surplus(surplus), .ack(irq_ack), .done(reconf_done),
    .irq(irq), .req(req_task), .loaded(status_task)
  );
endmodule

// File: rtl/rcfg_mgr_chk.sv
module rcfg_mgr_chk #(
  parameter int WIN = 15,
  parameter int PW  = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ckpt_valid,
  input logic          ckpt_ready,
  input logic [1:0]    ckpt_code,
  input logic          pwr_valid,
  input logic          pwr_ready,
  input logic [PW-1:0] pwr_sample,
  input logic [PW-1:0] reconf_thresh,
  input logic          irq,
  input logic          irq_ack,
  input logic          req_task,
  input logic          reconf_done,
  input logic          status_task
);
  localparam int SW = $clog2(WIN + 1);
  logic [SW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (ckpt_valid && (ckpt_code == 2'd1 || ckpt_code == 2'd2) && seen_q != SW'(WIN))
      seen_q <= seen_q + 1'b1;
  end

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_ready && pwr_ready);
  assert_hold_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack && !reconf_done |=> irq);
  assert_hold_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack && !reconf_done |=> $stable(req_task));
  assert_surplus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pwr_valid && (pwr_sample > reconf_thresh)));
  assert_differs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (req_task != status_task));
  assert_filled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(seen_q) == SW'(WIN)));
  assert_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_task) |-> $past(reconf_done));
endmodule

bind rcfg_mgr rcfg_mgr_chk #(.WIN(WIN), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ckpt_valid(ckpt_valid), .ckpt_ready(ckpt_ready),
  .ckpt_code(ckpt_code), .pwr_valid(pwr_valid), .pwr_ready(pwr_ready),
  .pwr_sample(pwr_sample), .reconf_thresh(reconf_thresh), .irq(irq),
  .irq_ack(irq_ack), .req_task(req_task), .reconf_done(reconf_done),
  .status_task(status_task)
);

// File: tb/tb_rcfg_mgr.sv
module tb_rcfg_mgr;
  localparam int PW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ckpt_valid = 0, pwr_valid = 0, irq_ack = 0, reconf_done = 0;
  logic [1:0] ckpt_code = 0;
  logic [PW-1:0] pwr_sample = 0, reconf_thresh = 12'd100;
  logic ckpt_ready, pwr_ready, irq, req_task, status_task;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rcfg_mgr #(.WIN(15), .PW(PW), .INIT_TASK(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ckpt_valid(ckpt_valid), .ckpt_ready(ckpt_ready),
    .ckpt_code(ckpt_code), .pwr_valid(pwr_valid), .pwr_ready(pwr_ready),
    .pwr_sample(pwr_sample), .reconf_thresh(reconf_thresh), .irq(irq),
    .irq_ack(irq_ack), .req_task(req_task), .reconf_done(reconf_done),
    .status_task(status_task)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_ckpt(input logic [1:0] code);
    ckpt_valid = 1; ckpt_code = code;
    step();
    ckpt_valid = 0;
  endtask

  task automatic send_pwr(input logic [PW-1:0] v);
    pwr_valid = 1; pwr_sample = v;
    step();
    pwr_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 req_task", req_task, 0);
    chk("R1 status_task", status_task, 0);
    chk("R10 ready", {ckpt_ready, pwr_ready}, 3);
  endtask

  task automatic t_fill_and_trigger();
    for (int i = 0; i < 14; i++) send_ckpt(2'd2);
    send_pwr(12'd500);
    chk("R4 no irq with 14 entries", irq, 0);
    // 15th checkpoint together with a burst sample
    ckpt_valid = 1; ckpt_code = 2'd2; pwr_valid = 1; pwr_sample = 12'd500;
    step();
    ckpt_valid = 0; pwr_valid = 0;
    chk("R4 same-edge checkpoint does not count", irq, 0);
    send_pwr(12'd100);
    chk("R5 equal to threshold", irq, 0);
    pwr_valid = 0; pwr_sample = 12'd900;
    step();
    chk("R10 invalid sample ignored", irq, 0);
    send_pwr(12'd101);
    chk("R11 irq after surplus beat", irq, 1);
    chk("R3 req_task majority task1", req_task, 1);
  endtask

  task automatic t_handshake();
    repeat (3) step();
    chk("R7 irq held", irq, 1);
    chk("R7 req stable", req_task, 1);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R7 irq cleared by ack", irq, 0);
    chk("R9 status before done", status_task, 0);
    send_pwr(12'd700);
    chk("R8 no request while busy", irq, 0);
    reconf_done = 1; step(); reconf_done = 0;
    chk("R9 status updated", status_task, 1);
    send_pwr(12'd700);
    chk("R6 preferred already loaded", irq, 0);
    reconf_done = 1; step(); reconf_done = 0;
    chk("R9 idle done ignored", status_task, 1);
  endtask

  task automatic t_sliding();
    for (int i = 0; i < 7; i++) send_ckpt(2'd1);
    send_pwr(12'd800);
    chk("R3 8 of 15 still task1", irq, 0);
    for (int i = 0; i < 10; i++) send_ckpt((i % 2) ? 2'd3 : 2'd0);
    send_pwr(12'd800);
    chk("R2 codes 0 and 3 dropped", irq, 0);
    send_ckpt(2'd1);
    send_pwr(12'd800);
    chk("R2 code1 tips window", irq, 1);
    chk("R3 req_task task0", req_task, 0);
    reconf_done = 1; step(); reconf_done = 0;
    chk("R9 done clears irq", irq, 0);
    chk("R9 status task0", status_task, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_and_trigger();
    t_handshake();
    t_sliding();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule